// File: doc/BRIEF.md
# Frame-Counted Channel Receive FIFO

This block buffers the bytes of one ISDN data channel on their way from the line side to a host register port. The line side hands over whole bytes with a valid strobe. It can also mark the last byte of a frame. Each byte is reordered and/or complemented as configured, then stored in an internal ring. The host reads the ring one byte per read strobe. It can see the write and read byte pointers and the write and read frame counters directly. Through a small command register it can advance its frame counter, empty the FIFO, or clear the sticky lost-data flag.

The byte pointers do not start at zero. They run over the window 0x080 to 0x1FF and wrap from the top back to 0x080. The frame counters are four bits wide. Occupancy is the modular difference of each pointer pair.

In frame mode, an end-of-frame mark closes a frame, and the interrupt output flags that complete frames are waiting. In streaming mode, the end-of-frame mark is ignored, and the interrupt is a level that compares the byte occupancy against a selectable threshold.

Top module: `frame_fifo_chan`

## Requirements
- R1: After reset, z1 and z2 are 0x080, hostRdData is 0x00 and lostFlag is 0. The write pointer z1 advances by one for each accepted line byte and wraps from 0x1FF to 0x080. Both pointers always stay inside 0x080..0x1FF.
- R2: byteCount equals z1 minus z2, plus 384 when that difference is negative. The FIFO holds at most 383 bytes.
- R3: f1 and f2 count from 0 to 15 and wrap from 15 to 0. frameCount equals f1 minus f2 modulo 16.
- R4: In frame mode (cfgTransparent=0), a line byte carrying lineEof closes a frame and increments f1. In streaming mode (cfgTransparent=1), lineEof has no effect on f1.
- R5: A command write with hostCmd bit 0 set increments f2 once, two clock edges after the write, but only if frameCount is nonzero. The command bit then clears by itself, so one write advances f2 exactly once.
- R6: A command write with hostCmd bit 1 set returns z1 and z2 to 0x080 and f1 and f2 to 0, leaving lostFlag unchanged.
- R7: lostFlag is sticky until a command write with hostCmd bit 2 set clears it.
- R8: A line byte offered while 383 bytes are held is dropped. z1 does not move and lostFlag is set.
- R9: Closing a frame while 15 frames are pending drops that whole frame. z1 returns to where the frame began, f1 is unchanged, and lostFlag is set.
- R10: A host read of a non-empty FIFO presents the oldest byte on hostRdData after the clock edge and advances z2. A read of an empty FIFO presents the idle byte (0x7E when cfgIdleOnes=0, 0xFF when 1) and leaves z2 unchanged.
- R11: The stored byte is the line byte with its bit order reversed when cfgMsbFirst=1, and complemented when cfgInvert=1. Both options may be combined.
- R12: In streaming mode, irq is high while byteCount is at or above 32 shifted left by cfgIrqSel, for cfgIrqSel 1..7 (64..4096 bytes). For cfgIrqSel 0, irq stays low. In frame mode, irq is high while frameCount is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineValid | input | 1 | Line byte strobe |
| lineByte | input | 8 | Line byte |
| lineEof | input | 1 | Marks the strobed byte as last of a frame |
| hostRd | input | 1 | Host data read strobe |
| hostRdData | output | 8 | Byte returned by the last host read |
| hostCmdWr | input | 1 | Command register write strobe |
| hostCmd | input | 3 | Command bits: 0 advance f2, 1 empty FIFO, 2 clear lost flag |
| cfgTransparent | input | 1 | 1 selects streaming mode, 0 frame mode |
| cfgIrqSel | input | 3 | Streaming interrupt threshold code |
| cfgIdleOnes | input | 1 | Idle byte select: 0 gives 0x7E, 1 gives 0xFF |
| cfgMsbFirst | input | 1 | Reverse bit order of stored bytes |
| cfgInvert | input | 1 | Complement stored bytes |
| z1 | output | 9 | Write byte pointer |
| z2 | output | 9 | Read byte pointer |
| f1 | output | 4 | Write frame counter |
| f2 | output | 4 | Read frame counter |
| byteCount | output | 9 | Bytes held |
| frameCount | output | 4 | Frames pending |
| lostFlag | output | 1 | Sticky lost-data flag |
| irq | output | 1 | Level interrupt |

## Verification
The byte path is driven with three patterns. A short streaming burst that includes an end-of-frame mark separates correct ordering from frame side effects in streaming mode. A fill of the whole ring, starting from an offset pointer position, exposes wrap errors at 0x1FF, off-by-one capacity, and each threshold edge of the interrupt. A run of one-byte frames up to the fifteen-frame limit, followed by a frame that must be discarded, separates a correct rewind of the write pointer from a mere flag. Scoreboarded reads after each pattern confirm that bytes which were dropped or rewound never reach the host, and that empty reads yield the idle byte.

// File: rtl/ffc_pkg.sv
package ffc_pkg;
  localparam int DW  = 8;
  localparam int ZW  = 9;
  localparam int ZLO = 'h080;
  localparam int ZHI = 'h1FF;
  localparam int FW  = 4;
  localparam int SW  = 3;

  typedef struct packed {
    logic clrLost;
    logic resFifo;
    logic advF;
  } hostCmd_t;

  typedef struct packed {
    logic          wrEn;
    logic [ZW-1:0] wrAddr;
    logic          rdEn;
    logic          rdEmpty;
    logic [ZW-1:0] rdAddr;
  } dpStrobe_t;
endpackage

// File: rtl/ffc_ctrl.sv
module ffc_ctrl
  import ffc_pkg::*;
#(
  parameter int ZLO_P = ZLO,
  parameter int ZHI_P = ZHI
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          lineValid,
  input  logic          lineEof,
  input  logic          hostRd,
  input  logic          hostCmdWr,
  input  logic [2:0]    hostCmd,
  input  logic          cfgTransparent,
  input  logic [SW-1:0] cfgIrqSel,
  output dpStrobe_t     strobe,
  output logic [ZW-1:0] z1,
  output logic [ZW-1:0] z2,
  output logic [FW-1:0] f1,
  output logic [FW-1:0] f2,
  output logic [ZW-1:0] byteCount,
  output logic [FW-1:0] frameCount,
  output logic          lostFlag,
  output logic          irq
);
  localparam int DEPTH = ZHI_P - ZLO_P + 1;
  localparam logic [FW-1:0] F_TOP = {FW{1'b1}};
  localparam int THR_W = 16;

  function automatic logic [ZW-1:0] zInc(input logic [ZW-1:0] z);
    return (z == ZW'(ZHI_P)) ? ZW'(ZLO_P) : z + 1'b1;
  endfunction

  hostCmd_t      cmdQ;
  logic [ZW-1:0] zStart;
  logic          empty, full, acceptWr, acceptRd;
  logic          closeReq, dropFrame, popFrame, setLost;
  logic [ZW-1:0] z1Adv;
  logic [THR_W-1:0] thr;
  int            dz;

  // self-clearing command register
  always_ff @(posedge clk) begin
    if (!rstN) cmdQ <= '0;
    else       cmdQ <= hostCmdWr ? hostCmd_t'(hostCmd) : '0;
  end

  always_comb begin
    dz = int'(z1) - int'(z2);
    if (dz < 0) dz = dz + DEPTH;
    byteCount  = ZW'(dz);
    frameCount = f1 - f2;
    empty      = (z1 == z2);
    full       = (zInc(z1) == z2);
    acceptWr   = lineValid && !full;
    z1Adv      = acceptWr ? zInc(z1) : z1;
    closeReq   = lineValid && lineEof && !cfgTransparent;
    dropFrame  = closeReq && (frameCount == F_TOP);
    acceptRd   = hostRd && !empty;
    popFrame   = cmdQ.advF && (frameCount != '0);
    setLost    = (lineValid && full) || dropFrame;
  end

  always_comb begin
    strobe.wrEn    = acceptWr && !cmdQ.resFifo;
    strobe.wrAddr  = z1;
    strobe.rdEn    = hostRd;
    strobe.rdEmpty = empty || cmdQ.resFifo;
    strobe.rdAddr  = z2;
  end

  always_ff @(posedge clk) begin
    if (!rstN || cmdQ.resFifo) begin
      z1     <= ZW'(ZLO_P);
      z2     <= ZW'(ZLO_P);
      zStart <= ZW'(ZLO_P);
      f1     <= '0;
      f2     <= '0;
    end else begin
      z1 <= dropFrame ? zStart : z1Adv;
      if (closeReq && !dropFrame) begin
        f1     <= f1 + 1'b1;
        zStart <= z1Adv;
      end
      if (acceptRd) z2 <= zInc(z2);
      if (popFrame) f2 <= f2 + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             lostFlag <= 1'b0;
    else if (setLost)      lostFlag <= 1'b1;
    else if (cmdQ.clrLost) lostFlag <= 1'b0;
  end

  always_comb begin
    thr = THR_W'(1) << (int'(cfgIrqSel) + 5);
    if (cfgTransparent) irq = (cfgIrqSel != '0) && (THR_W'(byteCount) >= thr);
    else                irq = (frameCount != '0);
  end

  assert_ptr_window_R1: assert property (@(posedge clk) disable iff (!rstN)
    (z1 >= ZW'(ZLO_P)) && (z1 <= ZW'(ZHI_P)) && (z2 >= ZW'(ZLO_P)) && (z2 <= ZW'(ZHI_P)));

  assert_frame_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (f1 != $past(f1)) |-> ((f1 == $past(f1) + 1'b1) || (f1 == '0)));

  assert_adv_once_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdQ.advF && !hostCmdWr) |=> !cmdQ.advF);

  assert_lost_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (lostFlag && !cmdQ.clrLost) |=> lostFlag);

  assert_full_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
    (lineValid && full && !lineEof && !cmdQ.resFifo) |=> ((z1 == $past(z1)) && lostFlag));

  assert_empty_read_R10: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && empty && !cmdQ.resFifo) |=> (z2 == $past(z2)));
endmodule

// File: rtl/ffc_datapath.sv
module ffc_datapath
  import ffc_pkg::*;
#(
  parameter int ZLO_P = ZLO,
  parameter int ZHI_P = ZHI
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     strobe,
  input  logic [DW-1:0] lineByte,
  input  logic          cfgIdleOnes,
  input  logic          cfgMsbFirst,
  input  logic          cfgInvert,
  output logic [DW-1:0] hostRdData
);
  localparam logic [DW-1:0] IDLE_FLAG = DW'('h7E);
  localparam logic [DW-1:0] IDLE_ONES = {DW{1'b1}};

  logic [DW-1:0] ring [ZLO_P:ZHI_P];
  logic [DW-1:0] revByte, wrByte, fillByte;

  for (genvar b = 0; b < DW; b++) begin : g_rev
    assign revByte[b] = lineByte[DW-1-b];
  end

  always_comb begin
    wrByte   = (cfgMsbFirst ? revByte : lineByte) ^ {DW{cfgInvert}};
    fillByte = cfgIdleOnes ? IDLE_ONES : IDLE_FLAG;
  end

  always_ff @(posedge clk) begin
    if (strobe.wrEn) ring[strobe.wrAddr] <= wrByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           hostRdData <= '0;
    else if (strobe.rdEn) hostRdData <= strobe.rdEmpty ? fillByte : ring[strobe.rdAddr];
  end

  assert_fill_on_empty_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdEn && strobe.rdEmpty) |=> (hostRdData == $past(fillByte)));
endmodule

// File: rtl/frame_fifo_chan.sv
module frame_fifo_chan
  import ffc_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          lineValid,
  input  logic [DW-1:0] lineByte,
  input  logic          lineEof,
  input  logic          hostRd,
  output logic [DW-1:0] hostRdData,
  input  logic          hostCmdWr,
  input  logic [2:0]    hostCmd,
  input  logic          cfgTransparent,
  input  logic [SW-1:0] cfgIrqSel,
  input  logic          cfgIdleOnes,
  input  logic          cfgMsbFirst,
  input  logic          cfgInvert,
  output logic [ZW-1:0] z1,
  output logic [ZW-1:0] z2,
  output logic [FW-1:0] f1,
  output logic [FW-1:0] f2,
  output logic [ZW-1:0] byteCount,
  output logic [FW-1:0] frameCount,
  output logic          lostFlag,
  output logic          irq
);
  dpStrobe_t strobe;

  ffc_ctrl #(.ZLO_P(ZLO), .ZHI_P(ZHI)) u_ctrl (
    .clk(clk), .rstN(rstN), .lineValid(lineValid), .lineEof(lineEof),
    .hostRd(hostRd), .hostCmdWr(hostCmdWr), .hostCmd(hostCmd),
    .cfgTransparent(cfgTransparent), .cfgIrqSel(cfgIrqSel), .strobe(strobe),
    .z1(z1), .z2(z2), .f1(f1), .f2(f2), .byteCount(byteCount),
    .frameCount(frameCount), .lostFlag(lostFlag), .irq(irq)
  );

  ffc_datapath #(.ZLO_P(ZLO), .ZHI_P(ZHI)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lineByte(lineByte),
    .cfgIdleOnes(cfgIdleOnes), .cfgMsbFirst(cfgMsbFirst), .cfgInvert(cfgInvert),
    .hostRdData(hostRdData)
  );
endmodule

// File: tb/sim_frame_fifo_chan.sv
module sim_frame_fifo_chan;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineValid = 0, lineEof = 0, hostRd = 0, hostCmdWr = 0;
  logic [7:0] lineByte = 0;
  logic [2:0] hostCmd = 0;
  logic cfgTransparent = 1, cfgIdleOnes = 0, cfgMsbFirst = 0, cfgInvert = 0;
  logic [2:0] cfgIrqSel = 0;
  logic [7:0] hostRdData;
  logic [8:0] z1, z2, byteCount;
  logic [3:0] f1, f2, frameCount;
  logic lostFlag, irq;

  int nChecks = 0;
  int nErr = 0;
  logic [7:0] expQ[$];
  logic rdSeen = 0;
  logic [7:0] expRd;
  logic [8:0] zMark;

  always #2 clk = ~clk;

  frame_fifo_chan u0 (
    .clk(clk), .rstN(rstN), .lineValid(lineValid), .lineByte(lineByte), .lineEof(lineEof),
    .hostRd(hostRd), .hostRdData(hostRdData), .hostCmdWr(hostCmdWr), .hostCmd(hostCmd),
    .cfgTransparent(cfgTransparent), .cfgIrqSel(cfgIrqSel), .cfgIdleOnes(cfgIdleOnes),
    .cfgMsbFirst(cfgMsbFirst), .cfgInvert(cfgInvert), .z1(z1), .z2(z2), .f1(f1), .f2(f2),
    .byteCount(byteCount), .frameCount(frameCount), .lostFlag(lostFlag), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] xform(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = cfgMsbFirst ? b[7-i] : b[i];
    return r ^ {8{cfgInvert}};
  endfunction

  // driver: offers one line byte, records it in the scoreboard if it must survive
  task automatic push(input logic [7:0] b, input logic eof, input logic keep);
    lineValid = 1; lineByte = b; lineEof = eof;
    if (keep) expQ.push_back(xform(b));
    @(negedge clk);
    lineValid = 0; lineEof = 0;
  endtask

  task automatic readN(input int n);
    for (int i = 0; i < n; i++) begin
      hostRd = 1;
      @(negedge clk);
    end
    hostRd = 0;
    @(negedge clk);
  endtask

  task automatic cmd(input logic [2:0] c);
    hostCmdWr = 1; hostCmd = c;
    @(negedge clk);
    hostCmdWr = 0; hostCmd = 0;
    @(negedge clk);
  endtask

  // monitor: compares each host read against the scoreboard or the idle byte
  always @(posedge clk) rdSeen <= hostRd && rstN;
  always @(negedge clk) begin
    if (rdSeen) begin
      expRd = (expQ.size() != 0) ? expQ.pop_front() : (cfgIdleOnes ? 8'hFF : 8'h7E);
      check("R10 read data", {24'd0, hostRdData}, {24'd0, expRd});
    end
  end

  initial begin
    #(4 * 200000);
    nErr++; nChecks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    check("R1 reset z1", z1, 9'h080);
    check("R1 reset z2", z2, 9'h080);
    check("R1 reset data", hostRdData, 8'h00);
    check("R1 reset lost", lostFlag, 0);
    check("R2 reset count", byteCount, 0);
    check("R3 reset frames", {f1, f2}, 8'h00);
    check("R12 code0 irq", irq, 0);
    @(negedge clk);

    // streaming burst, one byte marked end-of-frame
    push(8'hA1, 0, 1); push(8'h00, 0, 1); push(8'hFF, 1, 1); push(8'h3C, 0, 1); push(8'h96, 0, 1);
    #1;
    check("R2 count after burst", byteCount, 5);
    check("R4 eof ignored in streaming", f1, 0);
    @(negedge clk);
    readN(5);
    check("R10 z2 advanced", z2, 9'h085);

    // empty reads
    readN(1);
    check("R10 empty z2 stable", z2, 9'h085);
    cfgIdleOnes = 1;
    readN(1);
    check("R10 empty z2 stable ones", z2, 9'h085);
    cfgIdleOnes = 0;

    // transforms R11
    cfgMsbFirst = 1; push(8'h01, 0, 1);
    cfgMsbFirst = 0; cfgInvert = 1; push(8'h0F, 0, 1);
    cfgMsbFirst = 1; push(8'h03, 0, 1);
    cfgMsbFirst = 0; cfgInvert = 0;
    check("R11 bit reverse", expQ[0], 8'h80);
    check("R11 invert", expQ[1], 8'hF0);
    check("R11 both", expQ[2], 8'h3F);
    readN(3);

    // full fill from offset position, thresholds R12, wrap R1, overflow R8
    cfgIrqSel = 3'd2;
    for (int i = 0; i < 383; i++) begin
      push(8'(i) ^ 8'h5A, 0, 1);
      if (i == 126) begin #1; check("R12 below 128", irq, 0); end
      if (i == 127) begin #1; check("R12 at 128", irq, 1); end
    end
    #1;
    check("R1 z1 wrapped", z1, 9'h087);
    check("R2 count full", byteCount, 383);
    cfgIrqSel = 3'd3; #1; check("R12 code3 at 383", irq, 1);
    cfgIrqSel = 3'd4; #1; check("R12 code4 at 383", irq, 0);
    cfgIrqSel = 3'd0; #1; check("R12 code0 at 383", irq, 0);
    @(negedge clk);
    push(8'hEE, 0, 0);
    #1;
    check("R8 lost on full", lostFlag, 1);
    check("R8 z1 held", z1, 9'h087);
    @(negedge clk);
    readN(383);
    check("R2 empty after drain", byteCount, 0);
    check("R7 lost sticky", lostFlag, 1);

    // R6 reset command, R7 clear
    push(8'h44, 0, 0);
    cmd(3'b010);
    check("R6 z1 after reset cmd", z1, 9'h080);
    check("R6 z2 after reset cmd", z2, 9'h080);
    check("R6 lost kept", lostFlag, 1);
    cmd(3'b100);
    check("R7 lost cleared", lostFlag, 0);

    // frame mode
    cfgTransparent = 0;
    push(8'h11, 0, 1); push(8'h22, 1, 1);
    #1;
    check("R4 f1 after eof", f1, 1);
    check("R3 frame count", frameCount, 1);
    check("R12 frame irq", irq, 1);
    @(negedge clk);
    cmd(3'b001);
    check("R5 f2 advanced", f2, 1);
    check("R12 frame irq low", irq, 0);
    cmd(3'b001);
    check("R5 no advance when none pending", f2, 1);
    readN(2);

    // fifteen pending frames then a frame that must be discarded
    for (int i = 0; i < 15; i++) push(8'(8'h30 + i), 1, 1);
    #1;
    check("R3 f1 wrapped", f1, 0);
    check("R3 fifteen pending", frameCount, 15);
    zMark = z1;
    @(negedge clk);
    push(8'hAA, 0, 0); push(8'hBB, 1, 0);
    #1;
    check("R9 z1 rewound", z1, zMark);
    check("R9 lost set", lostFlag, 1);
    check("R9 f1 unchanged", f1, 0);
    @(negedge clk);
    readN(15);
    cmd(3'b001);
    repeat (3) @(negedge clk);
    check("R5 single advance", frameCount, 14);
    for (int i = 0; i < 14; i++) cmd(3'b001);
    check("R3 f2 wrapped", f2, 0);
    check("R3 none pending", frameCount, 0);

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule